// File: doc/BRIEF.md
# Pipelined Eight-Lane Stable Sorter

This block sorts a batch of eight signed 16-bit values into ascending order, and it can take a new batch on every clock. A batch is packed into one 128-bit word and is taken in on any rising edge where the valid input is high and reset is low. Six cycles later the sorted batch comes out on a 128-bit bus with the same lane layout. A 24-bit bus comes out with it and gives, for each output position, the input lane that the value came from. There is no ready signal and no stall. Every batch that enters produces exactly one result cycle, and back-to-back batches produce back-to-back results.

The sort is stable. Values that are equal keep the order of their input lanes, because the network orders (value, lane) pairs and those pairs are all distinct. Inside, the block is a 19-element compare-exchange network of depth six, with a register after each layer. A valid bit travels beside each layer's payload. When a stage holds no batch, its payload registers hold zero, so the outputs read zero on idle cycles without any extra output logic.

Top module: `lane_sort_pipe`

## Requirements
- R1: Lane k of the input and output data buses occupies bits [16k+15:16k]. Lane 0 is the least significant lane.
- R2: In a valid result, the values are in nondecreasing two's-complement signed order from position 0 up to position 7.
- R3: Equal values come out ordered by input lane, lowest lane first. Duplicate values pass through unchanged.
- R4: Field k of the index bus occupies bits [3k+2:3k]. It holds the input lane whose value appears at output position k, and together the eight fields form a permutation of 0 to 7.
- R5: A batch taken in on the edge that ends cycle N is presented with out_valid high during cycle N+6, never earlier and never later.
- R6: Each accepted batch gives exactly one valid output cycle. Batches accepted on consecutive cycles appear on consecutive cycles.
- R7: Reset is synchronous and active high. While reset is asserted no batch is accepted, any batch already in the pipeline is dropped, and out_valid, out_data and out_index are all zero.
- R8: On any cycle that does not carry a result, out_valid is low and both out_data and out_index read zero, whatever was on in_data when in_valid was low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Take in_data as a batch on this edge |
| in_data | input | 128 | Eight signed 16-bit input lanes |
| out_valid | output | 1 | A sorted batch is present this cycle |
| out_data | output | 128 | Eight sorted signed 16-bit lanes, smallest in lane 0 |
| out_index | output | 24 | Eight 3-bit origin lanes, one for each output position |

## Verification
On every cycle the assertions check that a valid result is in order under the signed-value-then-lane rule and that its index fields form a full permutation. They also check that idle outputs read zero, that each stage passes its valid bit one cycle later, and that a reset clears the valid bit. Some behaviour needs to know the input history, and only the bench scenarios can show it: that each output value really came from the lane named beside it, that the delay is exactly six cycles, and that in-flight batches vanish across a reset. To cover these, the bench runs a delay-line model against table vectors, long valid streaks, random gaps, heavy ties, signed extremes and a reset in the middle of a stream.

// File: rtl/lsort_pkg.sv
package lsort_pkg;

  localparam int LANES  = 8;
  localparam int IDX_W  = $clog2(LANES);
  localparam int LAYERS = 6;

  // Lane paired with 'lane' in network layer 'layer' (odd-even merge form).
  // A lane paired with itself passes through untouched in that layer.
  function automatic int partner(input int layer, input int lane);
    int p;
    p = lane;
    case (layer)
      0: p = lane ^ 1;
      1: p = lane ^ 2;
      2: begin
        if (lane == 1) p = 2;
        if (lane == 2) p = 1;
        if (lane == 5) p = 6;
        if (lane == 6) p = 5;
      end
      3: p = lane ^ 4;
      4: begin
        if (lane == 2) p = 4;
        if (lane == 4) p = 2;
        if (lane == 3) p = 5;
        if (lane == 5) p = 3;
      end
      default: begin
        if (lane == 1) p = 2;
        if (lane == 2) p = 1;
        if (lane == 3) p = 4;
        if (lane == 4) p = 3;
        if (lane == 5) p = 6;
        if (lane == 6) p = 5;
      end
    endcase
    return p;
  endfunction

endpackage

// File: rtl/lsort_cmp_exch.sv
// One compare-exchange element on {value, lane} words.
module lsort_cmp_exch #(
  parameter int DATA_W = 16,
  parameter int IDX_W  = 3,
  localparam int W     = DATA_W + IDX_W
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] lo,
  output logic [W-1:0] hi
);
  // Flip the sign bit so a single unsigned compare orders (signed value, lane).
  logic [W-1:0] key_a, key_b;
  logic         swap;

  always_comb begin
    key_a = {~a[W-1], a[W-2:0]};
    key_b = {~b[W-1], b[W-2:0]};
    swap  = key_b < key_a;
    lo    = swap ? b : a;
    hi    = swap ? a : b;
  end
endmodule

// File: rtl/lsort_stage.sv
// One network layer followed by its pipeline register.
module lsort_stage
  import lsort_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int LAYER  = 0,
  localparam int W     = DATA_W + IDX_W,
  localparam int BUS_W = LANES * W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [BUS_W-1:0] in_lanes,
  output logic             out_valid,
  output logic [BUS_W-1:0] out_lanes
);
  logic [W-1:0]     nxt [LANES];
  logic [BUS_W-1:0] nxt_flat;

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    localparam int P = partner(LAYER, k);
    if (P > k) begin : g_cx
      lsort_cmp_exch #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_cx (
        .a (in_lanes[k*W +: W]),
        .b (in_lanes[P*W +: W]),
        .lo(nxt[k]),
        .hi(nxt[P])
      );
    end else if (P == k) begin : g_pass
      assign nxt[k] = in_lanes[k*W +: W];
    end
    assign nxt_flat[k*W +: W] = nxt[k];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_lanes <= '0;
    end else begin
      out_valid <= in_valid;
      out_lanes <= in_valid ? nxt_flat : '0;
    end
  end

  logic prev_rst = 1'b1;
  always_ff @(posedge clk) prev_rst <= rst;

  // R5, R6: each stage hands its valid bit on after exactly one cycle
  assert_stage_advance_R6: assert property (@(posedge clk) disable iff (rst)
    !prev_rst |-> out_valid == $past(in_valid));

  // R7: a reset cycle leaves the stage empty
  assert_reset_clears_R7: assert property (@(posedge clk) disable iff (rst)
    prev_rst |-> !out_valid && out_lanes == '0);
endmodule

// File: rtl/lane_sort_pipe.sv
module lane_sort_pipe
  import lsort_pkg::*;
#(
  parameter int DATA_W = 16,
  localparam int W     = DATA_W + IDX_W,
  localparam int BUS_W = LANES * W
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      in_valid,
  input  logic [LANES*DATA_W-1:0]   in_data,
  output logic                      out_valid,
  output logic [LANES*DATA_W-1:0]   out_data,
  output logic [LANES*IDX_W-1:0]    out_index
);
  logic [BUS_W-1:0] chain  [LAYERS+1];
  logic             vchain [LAYERS+1];

  // Tag each input lane with its own lane number (R1, R4).
  for (genvar k = 0; k < LANES; k++) begin : g_tag
    assign chain[0][k*W +: W] = {in_data[k*DATA_W +: DATA_W], IDX_W'(k)};
  end
  assign vchain[0] = in_valid;

  for (genvar s = 0; s < LAYERS; s++) begin : g_stage
    lsort_stage #(.DATA_W(DATA_W), .LAYER(s)) u_stage (
      .clk      (clk),
      .rst      (rst),
      .in_valid (vchain[s]),
      .in_lanes (chain[s]),
      .out_valid(vchain[s+1]),
      .out_lanes(chain[s+1])
    );
  end

  assign out_valid = vchain[LAYERS];
  for (genvar k = 0; k < LANES; k++) begin : g_out
    assign out_data[k*DATA_W +: DATA_W] = chain[LAYERS][k*W+IDX_W +: DATA_W];
    assign out_index[k*IDX_W +: IDX_W]  = chain[LAYERS][k*W +: IDX_W];
  end

  // R2, R3: adjacent output positions follow (signed value, lane) order
  for (genvar k = 0; k < LANES-1; k++) begin : g_ord
    logic signed [DATA_W-1:0] v_lo, v_hi;
    logic        [IDX_W-1:0]  i_lo, i_hi;
    assign v_lo = out_data[k*DATA_W +: DATA_W];
    assign v_hi = out_data[(k+1)*DATA_W +: DATA_W];
    assign i_lo = out_index[k*IDX_W +: IDX_W];
    assign i_hi = out_index[(k+1)*IDX_W +: IDX_W];
    assert_sorted_pair_R2: assert property (@(posedge clk) disable iff (rst)
      out_valid |-> (v_lo < v_hi) || (v_lo == v_hi && i_lo < i_hi));
  end

  logic [LANES-1:0] seen;
  always_comb begin
    seen = '0;
    for (int k = 0; k < LANES; k++) seen[out_index[k*IDX_W +: IDX_W]] = 1'b1;
  end

  // R4: the origin fields of a result name every input lane once
  assert_index_perm_R4: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $countones(seen) == LANES);

  // R8: idle cycles present all-zero buses
  assert_idle_zero_R8: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> out_data == '0 && out_index == '0);
endmodule

// File: tb/test_lane_sort_pipe.sv
`timescale 1ns/1ps
module test_lane_sort_pipe;
  localparam int NV    = 4;
  localparam int LIMIT = 20000;

  // Stimulus and expected results; lane 0 is the rightmost field (R1).
  localparam logic [127:0] TV_IN [NV] = '{
    {16'h0008,16'h0007,16'h0006,16'h0005,16'h0004,16'h0003,16'h0002,16'h0001},
    {16'h0001,16'h0002,16'h0003,16'h0004,16'h0005,16'h0006,16'h0007,16'h0008},
    {16'h1234,16'h1234,16'h1234,16'h1234,16'h1234,16'h1234,16'h1234,16'h1234},
    {16'hFFFF,16'h0001,16'h8000,16'h7FFF,16'hFFFF,16'h0000,16'h8000,16'h7FFF}
  };
  localparam logic [127:0] TV_OUT [NV] = '{
    {16'h0008,16'h0007,16'h0006,16'h0005,16'h0004,16'h0003,16'h0002,16'h0001},
    {16'h0008,16'h0007,16'h0006,16'h0005,16'h0004,16'h0003,16'h0002,16'h0001},
    {16'h1234,16'h1234,16'h1234,16'h1234,16'h1234,16'h1234,16'h1234,16'h1234},
    {16'h7FFF,16'h7FFF,16'h0001,16'h0000,16'hFFFF,16'hFFFF,16'h8000,16'h8000}
  };
  localparam logic [23:0] TV_IDX [NV] = '{
    {3'd7,3'd6,3'd5,3'd4,3'd3,3'd2,3'd1,3'd0},
    {3'd0,3'd1,3'd2,3'd3,3'd4,3'd5,3'd6,3'd7},
    {3'd7,3'd6,3'd5,3'd4,3'd3,3'd2,3'd1,3'd0},
    {3'd4,3'd0,3'd6,3'd2,3'd7,3'd3,3'd5,3'd1}
  };

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         in_valid = 1'b0;
  logic [127:0] in_data = '0;
  logic         out_valid;
  logic [127:0] out_data;
  logic [23:0]  out_index;

  logic [127:0] exp_d = '0;
  logic [23:0]  exp_i = '0;
  logic         m_v [6] = '{default: 1'b0};
  logic [127:0] m_d [6] = '{default: '0};
  logic [23:0]  m_i [6] = '{default: '0};

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  lane_sort_pipe i_lane_sort_pipe (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
    .out_valid(out_valid), .out_data(out_data), .out_index(out_index)
  );

  // Stable ascending sort by rank counting of (signed value, lane) pairs.
  function automatic void ref_sort(input logic [127:0] d,
                                   output logic [127:0] od, output logic [23:0] oi);
    od = '0;
    oi = '0;
    for (int i = 0; i < 8; i++) begin
      int r = 0;
      for (int j = 0; j < 8; j++) begin
        if ($signed(d[j*16 +: 16]) < $signed(d[i*16 +: 16]) ||
            (d[j*16 +: 16] == d[i*16 +: 16] && j < i)) r++;
      end
      od[r*16 +: 16] = d[i*16 +: 16];
      oi[r*3 +: 3]   = 3'(i);
    end
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [127:0] act,
                     input logic [127:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at cycle %0d", tag, act, expv, cyc);
    end
  endtask

  // Six-deep delay line of expected results (R5, R6, R7).
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (rst) begin
      for (int i = 0; i < 6; i++) begin
        m_v[i] <= 1'b0; m_d[i] <= '0; m_i[i] <= '0;
      end
    end else begin
      m_v[0] <= in_valid;
      m_d[0] <= in_valid ? exp_d : '0;
      m_i[0] <= in_valid ? exp_i : '0;
      for (int i = 1; i < 6; i++) begin
        m_v[i] <= m_v[i-1]; m_d[i] <= m_d[i-1]; m_i[i] <= m_i[i-1];
      end
    end
  end

  always @(negedge clk) begin
    if (!finished) begin
      chk(out_valid == m_v[5], "R5 R6 valid timing", 128'(out_valid), 128'(m_v[5]));
      if (m_v[5]) begin
        chk(out_data == m_d[5], "R1 R2 R3 data", out_data, m_d[5]);
        chk(out_index == m_i[5], "R4 index", 128'(out_index), 128'(m_i[5]));
      end else begin
        chk(out_data == '0, "R7 R8 idle data", out_data, '0);
        chk(out_index == '0, "R7 R8 idle index", 128'(out_index), '0);
      end
    end
    if (cyc >= LIMIT && !finished) begin
      finished = 1'b1;
      errors++;
      checks++;
      $display("FAIL watchdog expired at cycle %0d", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic step(input bit v, input logic [127:0] d);
    logic [127:0] od;
    logic [23:0]  oi;
    ref_sort(d, od, oi);
    in_valid = v;
    in_data  = d;
    exp_d    = od;
    exp_i    = oi;
    @(negedge clk);
  endtask

  task automatic step_tv(input int n);
    in_valid = 1'b1;
    in_data  = TV_IN[n];
    exp_d    = TV_OUT[n];
    exp_i    = TV_IDX[n];
    @(negedge clk);
  endtask

  function automatic logic [127:0] rnd_batch(input bit tie_heavy);
    logic [127:0] d;
    for (int k = 0; k < 8; k++)
      d[k*16 +: 16] = tie_heavy ? 16'($urandom % 3) - 16'd1 : 16'($urandom);
    return d;
  endfunction

  initial begin
    // R7: outputs read zero during reset even with valid input present
    rst = 1'b1;
    in_valid = 1'b1;
    in_data = {8{16'h5A5A}};
    repeat (4) @(negedge clk);
    rst = 1'b0;
    step(1'b0, '0);

    // Table vectors back to back (R1, R2, R3, R4), then with gaps
    for (int n = 0; n < NV; n++) step_tv(n);
    repeat (8) step(1'b0, rnd_batch(1'b0));
    for (int n = 0; n < NV; n++) begin
      step_tv(n);
      repeat (n + 1) step(1'b0, rnd_batch(1'b0));
    end
    repeat (8) step(1'b0, '1);

    // Long valid streak (R6), mixed ties and extremes (R3)
    for (int n = 0; n < 300; n++) step(1'b1, rnd_batch(n % 3 == 0));

    // Random gaps; junk on in_data while idle (R8)
    for (int n = 0; n < 400; n++) step(($urandom % 5) < 3, rnd_batch(n % 2 == 0));
    repeat (8) step(1'b0, rnd_batch(1'b0));

    // Reset in mid-stream drops in-flight batches (R7)
    for (int n = 0; n < 4; n++) step(1'b1, rnd_batch(1'b0));
    rst = 1'b1;
    step(1'b1, rnd_batch(1'b0));
    step(1'b1, rnd_batch(1'b0));
    rst = 1'b0;
    for (int n = 0; n < 20; n++) step(1'b1, rnd_batch(n % 2 == 1));
    repeat (10) step(1'b0, '0);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule